// File: doc/BRIEF.md
# Ramped Pulse Train Generator

The block drives two periodic digital lines. A marker line (`sync_o`) goes high for a fixed 50-tick window at the start of every cycle. The moment the marker falls, the data line (`data_o`) plays a burst of pulses. Each pulse is high a little longer than the one before it, and every pulse is followed by the same low time. After the low time of the last pulse, both lines stay low for an idle gap, and then the next marker begins. The cycle period is therefore the marker window plus the burst plus the idle gap.

The four timing values arrive as small static integer codes. From them the block derives the first on-time, the off-time, the pulse count and the idle gap. Two push buttons are sampled through synchroniser and debounce stages:
- The enable button toggles whether the burst appears on `data_o`.
- The select button toggles between the normal burst and one alternative shape. A 2-bit input chooses that shape.

A tick prescaler derived from the clock frequency sets the time unit. Normally one tick is 1 us. When the `DEBUG` parameter is set, one tick is 1 ms, which slows every duration by a factor of 1000. A derived duration of zero is stretched to one tick.

Top module: `ramp_burst_gen`

## Requirements
- R1: While `rst_n` is low, `sync_o` is 1 and `data_o` is 0. After reset the data burst is disabled, the normal shape is active, and a new cycle starts in the marker window.
- R2: `sync_o` is high for exactly 50 ticks at the start of each cycle. The next cycle starts as soon as the idle gap of the current cycle ends.
- R3: When the burst is enabled, `data_o` rises on the same cycle that `sync_o` falls. The burst is built as follows:
  - In the normal shape there are `code_cnt_i`+4 pulses.
  - Pulse n (counting from 1) is high for `code_on_i`×100 + (n−1)×50 ticks.
  - Every pulse is followed by `code_off_i`×100 ticks low.
- R4: After the low time of the final pulse, both lines stay low for `code_idle_i`×500 ticks before the next marker.
- R5: Each debounced press of the enable button flips the enable state. While the burst is disabled, `data_o` stays 0, and `sync_o` keeps its cycle with the timing of the active shape.
- R6: Toggles of the enable state or the shape take effect only where the next marker begins. A burst already in progress always finishes in its original form.
- R7: Alternative shape `alt_sel_i`=0 plays 3 fewer pulses than the normal count.
- R8: Alternative shape `alt_sel_i`=1 plays the normal pulses in reverse order, longest first.
- R9: Alternative shape `alt_sel_i`=2 plays 3 more pulses than the normal count, and the 50-tick ramp continues through them.
- R10: Alternative shape `alt_sel_i`=3 halves both the off-time and the idle gap.
- R11: A button level must stay changed for `DEB_US` microseconds before it counts. A shorter glitch has no effect. Only a rising debounced level toggles state, so a single held press toggles exactly once.
- R12: With `DEBUG`=1, one tick lasts `CLK_HZ`/1000 clock cycles (1 ms). With `DEBUG`=0, one tick lasts `CLK_HZ`/1000000 cycles (1 us).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_en_i | input | 1 | Enable push button, active high, asynchronous |
| btn_sel_i | input | 1 | Shape-select push button, active high, asynchronous |
| code_on_i | input | CODE_W | First on-time code (×100 ticks) |
| code_off_i | input | CODE_W | Off-time code (×100 ticks) |
| code_cnt_i | input | CODE_W | Pulse count code (count = code + 4) |
| code_idle_i | input | CODE_W | Idle gap code (×500 ticks) |
| alt_sel_i | input | 2 | Alternative shape: 0 drop three, 1 reverse, 2 add three, 3 halve gaps |
| sync_o | output | 1 | Cycle marker |
| data_o | output | 1 | Pulse burst |

## Verification
The bench measures every run length on `data_o` across whole cycles, for each alternative shape. This catches several specific faults:
- An off-by-one pulse count would show up as a missing or extra run.
- A ramp that restarts after the normal count would show up as a wrong on-time.
- An off-time that merges wrongly with the idle gap would show up as a wrong final low run.

Button presses are placed inside a running burst. A design that applied them at once would visibly cut that burst short or reshape it. A glitch shorter than the debounce window is sent on the select button in the same cycle as a real enable press. If the glitch flipped the shape, the following disabled cycle would take the wrong length. Starting a new configuration from an enabled, alternative state checks that reset clears both toggles.

// File: rtl/rbg_pkg.sv
// Shared types and timing constants for the ramped pulse train generator.
// Assumes: all durations are expressed in ticks of the prescaler.
package rbg_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2,
        PH_IDLE = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        ALT_DROP    = 2'd0,
        ALT_REVERSE = 2'd1,
        ALT_EXTEND  = 2'd2,
        ALT_HALVE   = 2'd3
    } alt_t;

    localparam int SYNC_TICKS  = 50;
    localparam int RAMP_STEP   = 50;
    localparam int ON_UNIT     = 100;
    localparam int OFF_UNIT    = 100;
    localparam int IDLE_UNIT   = 500;
    localparam int BASE_PULSES = 4;
    localparam int PULSE_DELTA = 3;

endpackage

// File: rtl/rbg_tick.sv
// Free-running prescaler: raises tick_o for one cycle in every DIV cycles.
// Assumes: DIV >= 1; with DIV = 1 the tick is permanently high.
module rbg_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick_o = (cnt == CW'(DIV - 1));

    // Count clock cycles modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick_o)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/rbg_debounce.sv
// Two-flop synchroniser plus stable-count filter for one push button.
// press_o pulses for one cycle when the filtered level rises.
// Assumes: the button is active high and idles low.
module rbg_debounce #(
    parameter int DEB_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic press_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          meta_q;
    logic          sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt;

    // Synchronise, then accept a new level only after DEB_CYC agreeing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_q   <= 1'b0;
            stable_q <= 1'b0;
            cnt      <= '0;
            press_o  <= 1'b0;
        end else begin
            meta_q  <= btn_i;
            sync_q  <= meta_q;
            press_o <= 1'b0;
            if (sync_q != stable_q) begin
                if (cnt == CW'(DEB_CYC - 1)) begin
                    stable_q <= sync_q;
                    cnt      <= '0;
                    press_o  <= sync_q;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/rbg_sequencer.sv
// Phase sequencer: marker window, ramped pulses, off-times, idle gap.
// Latches the requested enable and shape at the start of each marker.
// Assumes: codes and alt_sel_i are static while out of reset.
module rbg_sequencer
    import rbg_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int DUR_W  = 16,
    parameter int PCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_req_i,
    input  logic              alt_req_i,
    input  logic [CODE_W-1:0] code_on_i,
    input  logic [CODE_W-1:0] code_off_i,
    input  logic [CODE_W-1:0] code_cnt_i,
    input  logic [CODE_W-1:0] code_idle_i,
    input  logic [1:0]        alt_sel_i,
    output logic              sync_o,
    output logic              data_o,
    output logic              en_act_o,
    output logic              alt_act_o
);
    phase_t             phase;
    logic [DUR_W-1:0]   tcnt;
    logic [PCNT_W-1:0]  pidx;
    alt_t               alt_mode;
    logic [PCNT_W-1:0]  n_base, n_pulses, last_idx, ramp_k;
    logic               halve;
    logic [DUR_W-1:0]   on_len, off_full, off_len, idle_full, idle_len;
    logic [DUR_W-1:0]   raw_len, phase_len;
    logic               phase_end;

    assign alt_mode = alt_t'(alt_sel_i);

    // Derive pulse count and ramp position from the active shape.
    always_comb begin
        n_base   = PCNT_W'(code_cnt_i) + PCNT_W'(BASE_PULSES);
        n_pulses = n_base;
        if (alt_act_o && alt_mode == ALT_DROP)
            n_pulses = n_base - PCNT_W'(PULSE_DELTA);
        else if (alt_act_o && alt_mode == ALT_EXTEND)
            n_pulses = n_base + PCNT_W'(PULSE_DELTA);
        last_idx = n_pulses - PCNT_W'(1);
        ramp_k   = (alt_act_o && alt_mode == ALT_REVERSE) ? (last_idx - pidx) : pidx;
        halve    = alt_act_o && (alt_mode == ALT_HALVE);
    end

    // Compute the length of the current phase in ticks.
    always_comb begin
        on_len    = DUR_W'(code_on_i) * DUR_W'(ON_UNIT) + DUR_W'(ramp_k) * DUR_W'(RAMP_STEP);
        off_full  = DUR_W'(code_off_i) * DUR_W'(OFF_UNIT);
        idle_full = DUR_W'(code_idle_i) * DUR_W'(IDLE_UNIT);
        off_len   = halve ? (off_full >> 1) : off_full;
        idle_len  = halve ? (idle_full >> 1) : idle_full;
        case (phase)
            PH_SYNC: raw_len = DUR_W'(SYNC_TICKS);
            PH_ON:   raw_len = on_len;
            PH_OFF:  raw_len = off_len;
            PH_IDLE: raw_len = idle_len;
            default: raw_len = DUR_W'(SYNC_TICKS);
        endcase
        phase_len = (raw_len == '0) ? DUR_W'(1) : raw_len;
        phase_end = tick_i && (tcnt == phase_len - DUR_W'(1));
    end

    // Step through phases on ticks; latch requests when a new marker starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_SYNC;
            tcnt      <= '0;
            pidx      <= '0;
            en_act_o  <= 1'b0;
            alt_act_o <= 1'b0;
        end else if (tick_i) begin
            if (phase_end) begin
                tcnt <= '0;
                case (phase)
                    PH_SYNC: begin
                        phase <= PH_ON;
                        pidx  <= '0;
                    end
                    PH_ON:   phase <= PH_OFF;
                    PH_OFF: begin
                        if (pidx == last_idx) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase <= PH_ON;
                            pidx  <= pidx + PCNT_W'(1);
                        end
                    end
                    default: begin
                        phase     <= PH_SYNC;
                        en_act_o  <= en_req_i;
                        alt_act_o <= alt_req_i;
                    end
                endcase
            end else begin
                tcnt <= tcnt + DUR_W'(1);
            end
        end
    end

    assign sync_o = (phase == PH_SYNC);
    assign data_o = en_act_o && (phase == PH_ON);

endmodule

// File: rtl/ramp_burst_gen.sv
// Top of the ramped pulse train generator: prescaler, two button filters,
// toggle registers and the phase sequencer.
// Assumes: CLK_HZ is a multiple of 1 MHz (or of 1 kHz when DEBUG = 1).
module ramp_burst_gen
    import rbg_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter bit DEBUG  = 1'b0,
    parameter int DEB_US = 10_000,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_en_i,
    input  logic              btn_sel_i,
    input  logic [CODE_W-1:0] code_on_i,
    input  logic [CODE_W-1:0] code_off_i,
    input  logic [CODE_W-1:0] code_cnt_i,
    input  logic [CODE_W-1:0] code_idle_i,
    input  logic [1:0]        alt_sel_i,
    output logic              sync_o,
    output logic              data_o
);
    localparam int TICK_DIV = DEBUG ? (CLK_HZ / 1000) : (CLK_HZ / 1_000_000);
    localparam int DEB_RAW  = (CLK_HZ / 1000) * DEB_US / 1000;
    localparam int DEB_CYC  = (DEB_RAW < 1) ? 1 : DEB_RAW;
    localparam int MAXC     = (1 << CODE_W) - 1;
    localparam int MAXN     = MAXC + BASE_PULSES + PULSE_DELTA;
    localparam int MAX_DUR  = MAXC * (IDLE_UNIT + ON_UNIT) + MAXN * RAMP_STEP;
    localparam int DUR_W    = $clog2(MAX_DUR + 1);
    localparam int PCNT_W   = $clog2(MAXN + 1);

    logic       tick;
    logic [1:0] btn_raw;
    logic [1:0] btn_press;
    logic       en_req, alt_req;
    logic       en_act, alt_act;

    assign btn_raw = {btn_sel_i, btn_en_i};

    rbg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar i = 0; i < 2; i++) begin : g_btn
        rbg_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .btn_i   (btn_raw[i]),
            .press_o (btn_press[i])
        );
    end

    // Flip the requested enable and shape on each filtered press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_req  <= 1'b0;
            alt_req <= 1'b0;
        end else begin
            if (btn_press[0]) en_req  <= ~en_req;
            if (btn_press[1]) alt_req <= ~alt_req;
        end
    end

    rbg_sequencer #(
        .CODE_W (CODE_W),
        .DUR_W  (DUR_W),
        .PCNT_W (PCNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .en_req_i    (en_req),
        .alt_req_i   (alt_req),
        .code_on_i   (code_on_i),
        .code_off_i  (code_off_i),
        .code_cnt_i  (code_cnt_i),
        .code_idle_i (code_idle_i),
        .alt_sel_i   (alt_sel_i),
        .sync_o      (sync_o),
        .data_o      (data_o),
        .en_act_o    (en_act),
        .alt_act_o   (alt_act)
    );

endmodule

// File: rtl/rbg_checker.sv
// Property checker for ramp_burst_gen, attached by bind below.
// Assumes: TICK_DIV matches the prescaler divisor of the bound instance.
module rbg_checker #(
    parameter int TICK_DIV = 1
) (
    input logic clk,
    input logic rst_n,
    input logic sync_o,
    input logic data_o,
    input logic en_act,
    input logic alt_act,
    input logic en_req,
    input logic alt_req,
    input logic press_en,
    input logic press_sel
);
    localparam int SYNC_CYC = 50 * TICK_DIV;

    int sync_run;

    // Count consecutive cycles with the marker high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_run <= 0;
        else
            sync_run <= sync_o ? sync_run + 1 : 0;
    end

    a_r2_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (sync_run < SYNC_CYC));

    a_r2_marker_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_o && data_o));

    a_r3_burst_follows_marker: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_o) && en_act) |-> data_o);

    a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |-> !data_o);

    a_r5_press_flips_enable: assert property (@(posedge clk) disable iff (!rst_n)
        press_en |=> (en_req != $past(en_req)));

    a_r6_enable_at_marker: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sync_o) |-> $stable(en_act));

    a_r6_shape_at_marker: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sync_o) |-> $stable(alt_act));

    a_r11_enable_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req != $past(en_req)) |-> $past(press_en));

    a_r11_shape_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_req != $past(alt_req)) |-> $past(press_sel));

endmodule

bind ramp_burst_gen rbg_checker #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_o    (sync_o),
    .data_o    (data_o),
    .en_act    (en_act),
    .alt_act   (alt_act),
    .en_req    (en_req),
    .alt_req   (alt_req),
    .press_en  (btn_press[0]),
    .press_sel (btn_press[1])
);

// File: tb/ramp_burst_gen_tb_top.sv
// Scoreboard bench: the driver queues expected run lengths of data_o per
// cycle; a negedge monitor measures runs and compares them.
module ramp_burst_gen_tb_top;

    localparam int CLK_HZ  = 2_000_000;
    localparam int DIV     = 2;
    localparam int DBG_DIV = 4;
    localparam int SYNC_T  = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_en = 1'b0;
    logic       btn_sel = 1'b0;
    logic [4:0] c_on = 5'd1, c_off = 5'd1, c_cnt = 5'd0, c_idle = 5'd1;
    logic [1:0] alt_sel = 2'd0;
    logic       sync_w, data_w, dbg_sync, dbg_data;

    always #5 clk = ~clk;

    ramp_burst_gen #(.CLK_HZ(CLK_HZ), .DEBUG(1'b0), .DEB_US(20), .CODE_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_en_i(btn_en), .btn_sel_i(btn_sel),
        .code_on_i(c_on), .code_off_i(c_off), .code_cnt_i(c_cnt), .code_idle_i(c_idle),
        .alt_sel_i(alt_sel), .sync_o(sync_w), .data_o(data_w)
    );

    ramp_burst_gen #(.CLK_HZ(4000), .DEBUG(1'b1), .DEB_US(20), .CODE_W(5)) dbg_i (
        .clk(clk), .rst_n(rst_n), .btn_en_i(1'b0), .btn_sel_i(1'b0),
        .code_on_i(5'd1), .code_off_i(5'd1), .code_cnt_i(5'd0), .code_idle_i(5'd1),
        .alt_sel_i(2'd0), .sync_o(dbg_sync), .data_o(dbg_data)
    );

    typedef struct {
        int    len;
        string req;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int len, input string req);
        item_t it;
        it.len = len;
        it.req = req;
        exp_q.push_back(it);
    endtask

    // Expected data_o runs for one cycle, from its marker rise to the next.
    task automatic push_frame(input bit en, input bit alt, input string tag);
        int n = int'(c_cnt) + 4;
        int b = int'(c_off) * 100;
        int d = int'(c_idle) * 500;
        bit rev = 1'b0;
        string pt = "R3", gt = "R3", it = "R4";
        int total = SYNC_T;
        if (alt) begin
            case (alt_sel)
                2'd0: begin n = n - 3; pt = "R7"; end
                2'd1: begin rev = 1'b1; pt = "R8"; end
                2'd2: begin n = n + 3; pt = "R9"; end
                default: begin b = b / 2; d = d / 2; gt = "R10"; it = "R10"; end
            endcase
        end
        if (tag != "") begin pt = tag; gt = tag; it = tag; end
        if (en) begin
            push(SYNC_T * DIV, (tag != "") ? tag : "R3");
            for (int i = 0; i < n; i++) begin
                int k = rev ? (n - 1 - i) : i;
                push((int'(c_on) * 100 + k * 50) * DIV, pt);
                if (i == n - 1) push((b + d) * DIV, it);
                else            push(b * DIV, gt);
            end
        end else begin
            for (int i = 0; i < n; i++) total += int'(c_on) * 100 + i * 50 + b;
            total += d;
            push(total * DIV, (tag != "") ? tag : "R5");
        end
    endtask

    // Monitor: measure runs between data edges and marker rises.
    bit p_sync = 1'b0, p_data = 1'b0, armed = 1'b0, ev;
    int run = 0, srun = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            armed = 1'b0;
            run   = 0;
            srun  = 0;
        end else begin
            ev = (data_w != p_data) || (sync_w && !p_sync);
            if (armed && ev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected run", run, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(run == it.len, it.req, run, it.len);
                end
                run = 1;
            end else if (!armed && sync_w && !p_sync) begin
                armed = 1'b1;
                run   = 1;
            end else begin
                run++;
            end
            if (sync_w && !p_sync) srun = 1;
            else if (sync_w)       srun++;
            if (armed && !sync_w && p_sync)
                check(srun == SYNC_T * DIV, "R2", srun, SYNC_T * DIV);
        end
        p_sync = sync_w;
        p_data = data_w;
    end

    // Debug-timescale instance: marker width must be 50 ms of ticks (R12).
    bit dp_sync = 1'b0, d_armed = 1'b0;
    int d_srun = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            d_armed = 1'b0;
            d_srun  = 0;
        end else begin
            if (dbg_sync && !dp_sync) begin
                d_armed = 1'b1;
                d_srun  = 1;
            end else if (dbg_sync) begin
                d_srun++;
            end
            if (d_armed && !dbg_sync && dp_sync)
                check(d_srun == SYNC_T * DBG_DIV, "R12", d_srun, SYNC_T * DBG_DIV);
        end
        dp_sync = dbg_sync;
    end

    task automatic do_reset(input int m1, input int m2, input int m3, input int m4, input int alt);
        @(posedge clk); #1;
        rst_n   = 1'b0;
        c_on    = 5'(m1);
        c_off   = 5'(m2);
        c_cnt   = 5'(m3);
        c_idle  = 5'(m4);
        alt_sel = 2'(alt);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sync_w == 1'b1, "R1 sync in reset", int'(sync_w), 1);
        check(data_w == 1'b0, "R1 data in reset", int'(data_w), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic press(input bit sel, input int hold);
        @(posedge clk); #1;
        if (sel) btn_sel = 1'b1; else btn_en = 1'b1;
        repeat (hold) @(posedge clk);
        #1;
        if (sel) btn_sel = 1'b0; else btn_en = 1'b0;
        repeat (100) @(posedge clk);
    endtask

    task automatic wait_rise;
        @(posedge sync_w);
    endtask

    task automatic run_config(input int m1, input int m2, input int m3, input int m4,
                              input int alt, input bit ext, input string t3);
        do_reset(m1, m2, m3, m4, alt);
        push_frame(1'b0, 1'b0, "");        // R1: disabled, normal after reset
        wait_rise();
        press(1'b0, 100);                  // R5: enable
        push_frame(1'b1, 1'b0, t3);
        wait_rise();
        press(1'b1, 100);                  // R6: shape change waits for marker
        push_frame(1'b1, 1'b1, "");
        wait_rise();
        if (ext) begin
            press(1'b1, 10);               // R11: glitch shorter than window
            press(1'b0, 100);              // R5: disable
            push_frame(1'b0, 1'b1, "R11");
            wait_rise();
        end
        wait_rise();
        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    endtask

    bit finished = 1'b0;

    initial begin
        run_config(1, 1, 0, 1, 0, 1'b0, "");     // R7 drop three
        run_config(2, 1, 1, 1, 1, 1'b0, "R6");   // R8 reversed
        run_config(1, 2, 0, 1, 2, 1'b0, "");     // R9 extended ramp
        run_config(1, 2, 1, 2, 3, 1'b1, "");     // R10 halved gaps, R11 glitch
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule